// File: doc/BRIEF.md
# Timer Output Compare Reference Generator

This block produces the internal reference level for one compare channel of a general-purpose timer. Each clock it looks at the running counter value, the counting direction, the channel's compare value and a 3-bit mode code, and works out the next reference level. Stages further down the chain turn that level into pin outputs. The counter itself, the prescaler, polarity selection and complementary pin handling sit outside this block. The counter value, the direction and the update event arrive on ports.

The mode code selects one of several behaviours:

- Freeze the level.
- On a compare match, drive the level active, drive it inactive, or toggle it.
- Force the level inactive or active.
- Follow one of two PWM rules that depend on the counting direction.

An external trigger can also clear the reference. When clearing is enabled and the trigger input is high, the level drops to 0. It then stays at 0 until the next update event, even after the trigger input falls. Every change is registered: the level seen on `ref_o` after a rising clock edge reflects the inputs present just before that edge.

Top module: `oc_ref_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until the first qualifying input, `ref_o` is 0.
- R2: `mode` = 4 drives `ref_o` to 0 after the next clock edge, whatever the counter and compare values.
- R3: `mode` = 5 drives `ref_o` to 1 after the next clock edge, whatever the counter and compare values, unless the trigger clear is in force (R10, R11).
- R4: `mode` = 6 with `dir_down` = 0 (counting up) gives `ref_o` = 1 when `cnt` < `cmp` and 0 otherwise.
- R5: `mode` = 6 with `dir_down` = 1 (counting down) gives `ref_o` = 0 when `cnt` > `cmp` and 1 otherwise.
- R6: `mode` = 7 gives the inverse of the `mode` 6 level for the same `cnt`, `cmp` and `dir_down`.
- R7: With `cmp` = 0, `mode` = 6 and counting up, `ref_o` stays 0 for every counter value.
- R8: When `cnt` equals `cmp`, `mode` = 1 sets the level to 1, `mode` = 2 clears it to 0 and `mode` = 3 inverts it. When they differ, these modes leave the level unchanged.
- R9: `mode` = 0 keeps the level unchanged whatever `cnt` and `cmp` do.
- R10: When `clr_en` = 1 and `ext_trig` = 1 at a clock edge, `ref_o` is 0 after that edge. This holds in every mode and also when `upd_evt` is high in the same cycle.
- R11: After such a clear, `ref_o` stays 0 while `ext_trig` is low, until a cycle with `upd_evt` = 1. After that edge `ref_o` again follows the selected mode.
- R12: With `clr_en` = 0, `ext_trig` has no effect on `ref_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt | input | CNT_W | Current counter value |
| dir_down | input | 1 | Counting direction: 1 = down, 0 = up |
| cmp | input | CNT_W | Channel compare value |
| mode | input | 3 | Compare mode code (0 to 7) |
| clr_en | input | 1 | Enables clearing by the external trigger |
| ext_trig | input | 1 | External trigger level |
| upd_evt | input | 1 | Timer update event, one cycle per pulse |
| ref_o | output | 1 | Registered output reference level |

## Verification
The bench builds the block with `CNT_W` = 8, so it can sweep every counter value for a given compare value in a few hundred cycles. That makes the full-period check with a compare value of 0 exhaustive. It also makes it cheap to probe the boundaries just below, at and just above the compare value in both counting directions. The narrow width also puts the top of the counter range (255) within reach of the PWM comparisons.

// File: rtl/oc_ref_gen.sv
module oc_ref_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir_down,
  input  logic [CNT_W-1:0] cmp,
  input  logic [2:0]       mode,
  input  logic             clr_en,
  input  logic             ext_trig,
  input  logic             upd_evt,
  output logic             ref_o
);

  localparam logic [2:0] M_FREEZE = 3'd0;
  localparam logic [2:0] M_SET    = 3'd1;
  localparam logic [2:0] M_RESET  = 3'd2;
  localparam logic [2:0] M_TOGGLE = 3'd3;
  localparam logic [2:0] M_LOW    = 3'd4;
  localparam logic [2:0] M_HIGH   = 3'd5;
  localparam logic [2:0] M_PWM_A  = 3'd6;
  localparam logic [2:0] M_PWM_B  = 3'd7;

  logic base_q, base_d;
  logic clr_q, clr_d;
  logic out_q;

  wire match   = (cnt == cmp);
  wire pwm_lvl = dir_down ? (cnt <= cmp) : (cnt < cmp);
  wire clr_hit = clr_en & ext_trig;

  always_comb begin
    base_d = base_q;
    case (mode)
      M_FREEZE: base_d = base_q;
      M_SET:    if (match) base_d = 1'b1;
      M_RESET:  if (match) base_d = 1'b0;
      M_TOGGLE: if (match) base_d = ~base_q;
      M_LOW:    base_d = 1'b0;
      M_HIGH:   base_d = 1'b1;
      M_PWM_A:  base_d = pwm_lvl;
      M_PWM_B:  base_d = ~pwm_lvl;
      default:  base_d = base_q;
    endcase
  end

  assign clr_d = clr_hit | (clr_q & ~upd_evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= 1'b0;
      clr_q  <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      clr_q  <= clr_d;
      out_q  <= base_d & ~clr_d;
    end
  end

  assign ref_o = out_q;

  p_force_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LOW) |=> !ref_o);

  p_force_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HIGH && !clr_hit && (!clr_q || upd_evt)) |=> ref_o);

  p_trig_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && ext_trig) |=> !ref_o);

  p_clear_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !upd_evt) |=> !ref_o);

  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FREEZE && !clr_q && !clr_hit) |=> $stable(ref_o));

  p_pwm_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PWM_A && !dir_down && !clr_hit && !clr_q) |=> (ref_o == $past(cnt < cmp)));

endmodule

// File: tb/oc_ref_gen_bench.sv
module oc_ref_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt = '0;
  logic         dir_down = 1'b0;
  logic [W-1:0] cmp = '0;
  logic [2:0]   mode = 3'd0;
  logic         clr_en = 1'b0;
  logic         ext_trig = 1'b0;
  logic         upd_evt = 1'b0;
  logic         ref_o;

  int n_tests = 0;
  int n_fail = 0;

  oc_ref_gen #(.CNT_W(W)) u_oc_ref_gen (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .dir_down(dir_down), .cmp(cmp),
    .mode(mode), .clr_en(clr_en), .ext_trig(ext_trig), .upd_evt(upd_evt),
    .ref_o(ref_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic exp);
    n_tests++;
    if (ref_o !== exp) begin
      n_fail++;
      $display("FAIL %s: ref_o=%b expected=%b (mode=%0d cnt=%0d cmp=%0d dir=%b)",
               req, ref_o, exp, mode, cnt, cmp, dir_down);
    end
  endtask

  // drive at negedge, one rising edge, sample at next negedge
  task automatic step(input logic [2:0] m, input logic [W-1:0] c, input logic [W-1:0] k,
                      input logic d, input logic ce, input logic tr, input logic up);
    mode = m; cnt = c; cmp = k; dir_down = d; clr_en = ce; ext_trig = tr; upd_evt = up;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(3'd5, 8'd3, 8'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R1 in reset", 1'b0);
    rst_n = 1'b1;
    step(3'd0, 8'd3, 8'd9, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R1 after release", 1'b0);
  endtask

  task automatic t_force;
    step(3'd5, 8'd200, 8'd10, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R3 force high", 1'b1);
    step(3'd5, 8'd0, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 force high at match", 1'b1);
    step(3'd4, 8'd1, 8'd50, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R2 force low", 1'b0);
    step(3'd4, 8'd50, 8'd50, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 force low at match", 1'b0);
  endtask

  task automatic t_pwm;
    logic [W-1:0] vals [7] = '{8'd0, 8'd99, 8'd100, 8'd101, 8'd150, 8'd255, 8'd42};
    foreach (vals[i]) begin
      step(3'd6, vals[i], 8'd100, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R4 pwm6 up", vals[i] < 8'd100);
      step(3'd6, vals[i], 8'd100, 1'b1, 1'b0, 1'b0, 1'b0);
      check("R5 pwm6 down", !(vals[i] > 8'd100));
      step(3'd7, vals[i], 8'd100, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R6 pwm7 up", !(vals[i] < 8'd100));
      step(3'd7, vals[i], 8'd100, 1'b1, 1'b0, 1'b0, 1'b0);
      check("R6 pwm7 down", vals[i] > 8'd100);
    end
  endtask

  task automatic t_cmp_zero;
    for (int c = 0; c < 256; c++) begin
      step(3'd6, c[W-1:0], 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R7 cmp zero up", 1'b0);
    end
  endtask

  task automatic t_match_modes;
    step(3'd5, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(3'd2, 8'd7, 8'd8, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 mode2 no match holds", 1'b1);
    step(3'd2, 8'd8, 8'd8, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 mode2 match clears", 1'b0);
    step(3'd1, 8'd9, 8'd8, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R8 mode1 no match holds", 1'b0);
    step(3'd1, 8'd8, 8'd8, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R8 mode1 match sets", 1'b1);
    step(3'd3, 8'd8, 8'd8, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 mode3 match toggles", 1'b0);
    step(3'd3, 8'd8, 8'd8, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 mode3 match toggles back", 1'b1);
    step(3'd3, 8'd9, 8'd8, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 mode3 no match holds", 1'b1);
  endtask

  task automatic t_freeze;
    step(3'd5, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(3'd0, 8'd0, 8'd200, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 freeze high", 1'b1);
    step(3'd0, 8'd200, 8'd200, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R9 freeze high at match", 1'b1);
    step(3'd4, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(3'd0, 8'd5, 8'd5, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 freeze low", 1'b0);
  endtask

  task automatic t_clear;
    step(3'd5, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R3 high before clear", 1'b1);
    step(3'd5, 8'd0, 8'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R10 trigger clears", 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(3'd5, 8'd0, 8'd0, 1'b0, 1'b1, 1'b0, 1'b0);
      check("R11 held low after trigger", 1'b0);
    end
    step(3'd5, 8'd0, 8'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R11 update releases", 1'b1);
    step(3'd5, 8'd0, 8'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R10 trigger beats update", 1'b0);
    step(3'd6, 8'd3, 8'd10, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R11 held low in pwm", 1'b0);
    step(3'd6, 8'd3, 8'd10, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R11 pwm resumes after update", 1'b1);
    step(3'd5, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R12 trigger ignored when disabled", 1'b1);
    step(3'd5, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R12 still high after ignored trigger", 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_force();
    t_pwm();
    t_cmp_zero();
    t_match_modes();
    t_freeze();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule